// File: doc/BRIEF.md
# Predicated Byte Write-Enable Unit

This unit sits between a SIMD execution result and a register file whose write port has one enable line per byte. It receives a 64-bit result word, an eight-bit predicate, an element-width code, a zeroing-mode bit and a predicate-invert bit. From these it forms the byte enables and the write data for one register write. The destination's old value never has to be read.

The predicate is optionally complemented, and each bit is then stretched over the bytes of its element. In merging (non-zeroing) mode the stretched mask becomes the byte enables, so masked-out bytes of the destination are simply not written. In zeroing mode every byte is enabled and the bytes of masked-out elements carry 0x00. All outputs are registered. The unit accepts one write per cycle and presents it one cycle later.

Top module: `pred_wren_unit`

## Requirements
- R1: While reset is asserted and after it is released, `wr_valid` is 0 and `wr_byte_en` is 0 until the first accepted write.
- R2: A write presented with `in_valid`=1 appears on `wr_valid`, `wr_dst` one clock later. `in_valid`=0 gives `wr_valid`=0 one clock later.
- R3: `in_width` selects the element size: 0 = 8-bit, 1 = 16-bit, 2 = 32-bit, 3 = 64-bit. Byte b (bits 8b+7..8b) belongs to element b / 2^in_width, and that element is governed by predicate bit number b / 2^in_width.
- R4: Predicate bits at or above the element count (8, 4, 2 or 1) have no effect on the outputs.
- R5: With `in_invert`=1 every predicate bit is complemented before use.
- R6: With `in_zeroing`=0, `wr_byte_en[b]` is 1 exactly for bytes of active elements, and `wr_data` carries the result bytes unchanged. Masked-out destination bytes therefore keep their old value.
- R7: With `in_zeroing`=1, all eight `wr_byte_en` bits are 1, active bytes carry the result, and masked-out bytes carry 0x00.
- R8: When `wr_valid` is 0, `wr_byte_en` is 0, whatever predicate or mode is presented.
- R9: Writes on consecutive cycles are each delivered on consecutive cycles without loss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | A write is presented this cycle |
| in_dst | input | 5 | Destination register index |
| in_result | input | 64 | Result word from the execution unit |
| in_pred | input | 8 | Predicate, bit i for element i |
| in_width | input | 2 | Element-width code (see R3) |
| in_zeroing | input | 1 | 1 = zeroing mode, 0 = merging mode |
| in_invert | input | 1 | 1 = complement the predicate |
| wr_valid | output | 1 | Registered write valid |
| wr_dst | output | 5 | Registered destination index |
| wr_byte_en | output | 8 | Registered per-byte write enables |
| wr_data | output | 64 | Registered write data |

## Verification
The hardest case to reach is merging mode, where a masked-out byte must keep a value written earlier. An output-only check cannot see that. The bench therefore keeps a software register file that it preloads with distinct byte patterns. It applies `wr_byte_en` to that file and compares the whole register after every write, for every width, both modes, both invert settings, the all-zero and all-one predicates, and predicates with stray high bits set. Idle cycles with a full predicate are placed between writes to show that nothing is enabled.

// File: rtl/pwe_pkg.sv
package pwe_pkg;
  localparam int unsigned DATA_W  = 64;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned NBYTES  = DATA_W / BYTE_W;
  localparam int unsigned PRED_W  = NBYTES;
  localparam int unsigned WCODE_W = $clog2($clog2(NBYTES) + 1);
  localparam int unsigned DST_W   = 5;

  typedef struct packed {
    logic                valid;
    logic [DST_W-1:0]    dst;
    logic [NBYTES-1:0]   byte_en;
    logic [DATA_W-1:0]   data;
  } wr_pkt_t;
endpackage

// File: rtl/pwe_rst_sync.sv
module pwe_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/pwe_lane_expand.sv
module pwe_lane_expand
  import pwe_pkg::*;
#(
  parameter int unsigned N_LANES = NBYTES,
  parameter int unsigned P_W     = PRED_W,
  parameter int unsigned W_W     = WCODE_W
) (
  input  logic [P_W-1:0]     pred,
  input  logic               invert,
  input  logic [W_W-1:0]     width,
  output logic [N_LANES-1:0] lane_on
);
  localparam int unsigned SEL_W = $clog2(P_W);
  logic [P_W-1:0] eff_pred;

  assign eff_pred = pred ^ {P_W{invert}};

  for (genvar b = 0; b < N_LANES; b++) begin : g_lane
    localparam logic [SEL_W-1:0] LANE_ID = SEL_W'(b);
    logic [SEL_W-1:0] elem_sel;
    assign elem_sel   = LANE_ID >> width;
    assign lane_on[b] = eff_pred[elem_sel];
  end
endmodule

// File: rtl/pwe_gate.sv
module pwe_gate
  import pwe_pkg::*;
#(
  parameter int unsigned N_LANES = NBYTES,
  parameter int unsigned L_W     = BYTE_W
) (
  input  logic                 valid,
  input  logic                 zeroing,
  input  logic [N_LANES-1:0]   lane_on,
  input  logic [N_LANES*L_W-1:0] result,
  output logic [N_LANES-1:0]   byte_en,
  output logic [N_LANES*L_W-1:0] data
);
  for (genvar b = 0; b < N_LANES; b++) begin : g_byte
    always_comb begin
      if (!valid)       byte_en[b] = 1'b0;
      else if (zeroing) byte_en[b] = 1'b1;
      else              byte_en[b] = lane_on[b];

      if (zeroing && !lane_on[b]) data[b*L_W +: L_W] = '0;
      else                        data[b*L_W +: L_W] = result[b*L_W +: L_W];
    end
  end
endmodule

// File: rtl/pwe_out_stage.sv
module pwe_out_stage
  import pwe_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  wr_pkt_t pkt_d,
  output wr_pkt_t pkt_q
);
  logic              valid_n, valid_r;
  logic [NBYTES-1:0] be_n, be_r;
  logic              load_en;
  logic [DST_W-1:0]  dst_r;
  logic [DATA_W-1:0] data_r;

  assign load_en = pkt_d.valid;

  always_comb begin
    valid_n = pkt_d.valid;
    be_n    = pkt_d.valid ? pkt_d.byte_en : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_r <= 1'b0;
      be_r    <= '0;
    end else begin
      valid_r <= valid_n;
      be_r    <= be_n;
    end
  end

  always_ff @(posedge clk) begin
    if (load_en) begin
      dst_r  <= pkt_d.dst;
      data_r <= pkt_d.data;
    end
  end

  assign pkt_q.valid   = valid_r;
  assign pkt_q.byte_en = be_r;
  assign pkt_q.dst     = dst_r;
  assign pkt_q.data    = data_r;
endmodule

// File: rtl/pred_wren_unit.sv
module pred_wren_unit
  import pwe_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [DST_W-1:0]   in_dst,
  input  logic [DATA_W-1:0]  in_result,
  input  logic [PRED_W-1:0]  in_pred,
  input  logic [WCODE_W-1:0] in_width,
  input  logic               in_zeroing,
  input  logic               in_invert,
  output logic               wr_valid,
  output logic [DST_W-1:0]   wr_dst,
  output logic [NBYTES-1:0]  wr_byte_en,
  output logic [DATA_W-1:0]  wr_data
);
  logic              rst_n_s;
  logic [NBYTES-1:0] lane_on;
  logic [NBYTES-1:0] be_c;
  logic [DATA_W-1:0] data_c;
  wr_pkt_t           pkt_d, pkt_q;

  pwe_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  pwe_lane_expand u_expand (
    .pred(in_pred), .invert(in_invert), .width(in_width), .lane_on(lane_on)
  );

  pwe_gate u_gate (
    .valid(in_valid), .zeroing(in_zeroing), .lane_on(lane_on),
    .result(in_result), .byte_en(be_c), .data(data_c)
  );

  always_comb begin
    pkt_d.valid   = in_valid;
    pkt_d.dst     = in_dst;
    pkt_d.byte_en = be_c;
    pkt_d.data    = data_c;
  end

  pwe_out_stage u_out (
    .clk(clk), .rst_n(rst_n_s), .pkt_d(pkt_d), .pkt_q(pkt_q)
  );

  assign wr_valid   = pkt_q.valid;
  assign wr_dst     = pkt_q.dst;
  assign wr_byte_en = pkt_q.byte_en;
  assign wr_data    = pkt_q.data;
endmodule

// File: rtl/pwe_checker.sv
module pwe_checker
  import pwe_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic [DST_W-1:0]   in_dst,
  input logic [PRED_W-1:0]  in_pred,
  input logic [WCODE_W-1:0] in_width,
  input logic               in_zeroing,
  input logic               in_invert,
  input logic               wr_valid,
  input logic [DST_W-1:0]   wr_dst,
  input logic [NBYTES-1:0]  wr_byte_en,
  input logic [DATA_W-1:0]  wr_data
);
  always_comb begin
    if (!rst_n) assert_reset_idle_R1: assert (!wr_valid && wr_byte_en == '0);
  end

  assert_idle_no_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_valid |-> wr_byte_en == '0);

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> wr_valid);

  assert_idle_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !wr_valid);

  assert_dst_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> wr_dst == $past(in_dst));

  assert_zero_full_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_zeroing) |=> wr_byte_en == '1);

  assert_wide_invert_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_zeroing && in_width == '1) |=>
      wr_byte_en == {NBYTES{$past(in_pred[0] ^ in_invert)}});

  assert_zero_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_zeroing && in_width == '1 && !(in_pred[0] ^ in_invert))
      |=> wr_data == '0);
endmodule

bind pred_wren_unit pwe_checker u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dst(in_dst),
  .in_pred(in_pred), .in_width(in_width), .in_zeroing(in_zeroing),
  .in_invert(in_invert), .wr_valid(wr_valid), .wr_dst(wr_dst),
  .wr_byte_en(wr_byte_en), .wr_data(wr_data)
);

// File: tb/sim_pred_wren_unit.sv
module sim_pred_wren_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [4:0]  in_dst = '0;
  logic [63:0] in_result = '0;
  logic [7:0]  in_pred = '0;
  logic [1:0]  in_width = '0;
  logic        in_zeroing = 1'b0;
  logic        in_invert = 1'b0;
  logic        wr_valid;
  logic [4:0]  wr_dst;
  logic [7:0]  wr_byte_en;
  logic [63:0] wr_data;

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  logic [63:0] rf_dut [32];
  logic [63:0] rf_ref [32];

  always #(CLK_PERIOD/2) clk = ~clk;

  pred_wren_unit u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dst(in_dst),
    .in_result(in_result), .in_pred(in_pred), .in_width(in_width),
    .in_zeroing(in_zeroing), .in_invert(in_invert), .wr_valid(wr_valid),
    .wr_dst(wr_dst), .wr_byte_en(wr_byte_en), .wr_data(wr_data)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic active(input logic [7:0] p, input bit inv, input int w, input int b);
    int sz = 1 << w;
    logic [7:0] e = inv ? ~p : p;
    return e[b / sz];
  endfunction

  task automatic do_write(input int dst, input logic [63:0] res, input logic [7:0] p,
                          input int w, input bit z, input bit inv, input string req);
    logic [7:0] exp_be;
    @(negedge clk);
    in_valid = 1'b1; in_dst = 5'(dst); in_result = res; in_pred = p;
    in_width = 2'(w); in_zeroing = z; in_invert = inv;
    for (int b = 0; b < 8; b++) begin
      logic on = active(p, inv, w, b);
      exp_be[b] = z ? 1'b1 : on;
      if (on)     rf_ref[dst][8*b +: 8] = res[8*b +: 8];
      else if (z) rf_ref[dst][8*b +: 8] = 8'h00;
    end
    @(posedge clk); #1;
    check("R2 valid", 64'(wr_valid), 64'd1);
    check("R9 dst", 64'(wr_dst), 64'(dst));
    check(req, 64'(wr_byte_en), 64'(exp_be));
    for (int b = 0; b < 8; b++)
      if (wr_byte_en[b]) rf_dut[wr_dst][8*b +: 8] = wr_data[8*b +: 8];
    check(req, rf_dut[dst], rf_ref[dst]);
  endtask

  task automatic do_idle(input logic [7:0] p, input bit z);
    @(negedge clk);
    in_valid = 1'b0; in_pred = p; in_zeroing = z; in_invert = 1'b0;
    @(posedge clk); #1;
    check("R8 idle enables", 64'(wr_byte_en), 64'd0);
    check("R2 idle valid", 64'(wr_valid), 64'd0);
  endtask

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        fails++;
        tests++;
        $display("FAIL watchdog actual=%0d expected<=100000", cycles);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    end
  end

  initial begin : stim
    logic [7:0] preds [6] = '{8'h00, 8'hFF, 8'hA5, 8'h3C, 8'h96, 8'hFE};
    int n = 0;
    for (int r = 0; r < 32; r++) begin
      rf_dut[r] = {8{8'(r)}} ^ 64'h0123_4567_89AB_CDEF;
      rf_ref[r] = rf_dut[r];
    end
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset valid", 64'(wr_valid), 64'd0);
    check("R1 reset enables", 64'(wr_byte_en), 64'd0);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    check("R1 post-reset enables", 64'(wr_byte_en), 64'd0);

    for (int w = 0; w < 4; w++)
      for (int z = 0; z < 2; z++)
        for (int inv = 0; inv < 2; inv++)
          for (int k = 0; k < 6; k++) begin
            do_write(n % 32, {8{8'(n + 8'h11)}} ^ 64'hF0E1_D2C3_B4A5_9687,
                     preds[k], w, bit'(z), bit'(inv),
                     z ? "R7 R3 R5 zeroing" : "R6 R3 R5 merging");
            n++;
          end

    // R4: stray high predicate bits must not change enables
    do_write(3, 64'h1111_2222_3333_4444, 8'hFE, 3, 1'b0, 1'b0, "R4 width64 high bits");
    do_write(4, 64'h5555_6666_7777_8888, 8'hFD, 2, 1'b0, 1'b0, "R4 width32 high bits");
    do_write(5, 64'h9999_AAAA_BBBB_CCCC, 8'hF5, 1, 1'b1, 1'b0, "R4 width16 high bits");

    // R8: idle cycles with a full predicate enable nothing
    do_idle(8'hFF, 1'b0);
    do_idle(8'hFF, 1'b1);

    // R9: back-to-back after idle
    do_write(7, 64'hCAFE_F00D_1234_5678, 8'h0F, 0, 1'b0, 1'b1, "R9 R6 back-to-back");
    do_write(8, 64'h0BAD_BEEF_8765_4321, 8'h55, 0, 1'b1, 1'b0, "R9 R7 back-to-back");
    do_idle(8'h00, 1'b0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule